// File: doc/BRIEF.md
# Write-Back Update Coherence Controller

This block is the coherence controller of one private write-back cache in a small snooping multiprocessor. It keeps copies current by broadcasting data rather than invalidating it. A resident line is always in one of four states: exclusive-clean, shared-clean, shared-modified or modified. When a processor writes to a block that other caches also hold, the controller puts a one-word update transaction on the bus. Every holder merges that word into its copy, and the writer becomes the single owner of the dirty block. A block that is not resident is simply absent. Read misses and write misses are handled as separate events.

On the processor side, a request is held until the controller pulses its done strobe. On the bus side, the controller raises a request with a command and waits for a one-cycle grant. In the grant cycle the environment returns the wired-OR shared line and, for reads, the fill block. Transactions from other caches arrive on the snoop inputs. In the same cycle the controller drives its contribution to the shared line and, when it owns dirty data, flushes the whole block. The cache is direct-mapped, and a block moves as a single wide beat.

Top module: `wbu_coherence_ctrl`

## Requirements
- R1: After reset no line is resident. The controller raises no bus request and no done strobe, and a snooped read to any block gets neither the shared line nor a flush.
- R2: A read miss issues one bus read (command code 1) for the block. If the shared line was low at the grant, the line becomes exclusive-clean. The request completes with the addressed word of the fill block.
- R3: A read miss answered with the shared line high leaves the line shared-clean. A later write issues a bus update (command code 2) carrying the word offset and the data. If the shared line is high at that grant, the line ends shared-modified.
- R4: A processor write to a shared-clean or shared-modified line issues a bus update. If the shared line is low at its grant, the line becomes modified.
- R5: A write miss with the shared line low issues exactly one bus read and leaves the line modified, holding the written word.
- R6: A write miss with the shared line high issues a bus read and then a bus update, in that order, and leaves the line shared-modified.
- R7: A snooped update (command code 2) to a resident block asserts the shared line and writes the broadcast word into the local copy. A shared-modified holder becomes shared-clean and no longer flushes.
- R8: A snooped read (command code 1) to a modified or shared-modified line asserts the shared line and flushes the block. Modified becomes shared-modified, and shared-modified stays as it is.
- R9: A processor write to an exclusive-clean line completes with no bus transaction and leaves it modified. A snooped read to an exclusive-clean line asserts the shared line without a flush and leaves it shared-clean.
- R10: A miss whose victim line is modified or shared-modified first issues a writeback (command code 3) with the victim's block address and data, then the bus read. A clean victim is dropped with no writeback.
- R11: Snooped transactions to a block that is not resident assert neither the shared line nor a flush, and they leave the resident line at that index unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuReq | input | 1 | Processor request, held until done |
| cpuWr | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | Word address: block address above the word offset |
| cpuWdata | input | WORD_W | Write data |
| cpuRdata | output | WORD_W | Read data, valid with cpuDone |
| cpuDone | output | 1 | Request completes this cycle |
| busReq | output | 1 | Bus request, held until granted |
| busGnt | input | 1 | One-cycle grant; the transaction takes place in this cycle |
| busCmd | output | 2 | 1 read, 2 update, 3 writeback |
| busAddr | output | ADDR_W-log2(WORDS) | Block address of the transaction |
| busWord | output | log2(WORDS) | Word offset of an update |
| busWordData | output | WORD_W | Word carried by an update |
| busBlockOut | output | WORDS*WORD_W | Block carried by a writeback |
| busFillData | input | WORDS*WORD_W | Fill block returned for a bus read |
| busShared | input | 1 | Wired-OR shared line, sampled at the grant |
| snpValid | input | 1 | Another cache's transaction is on the bus |
| snpCmd | input | 2 | Snooped command, same codes as busCmd |
| snpAddr | input | ADDR_W-log2(WORDS) | Snooped block address |
| snpWord | input | log2(WORDS) | Snooped update word offset |
| snpWordData | input | WORD_W | Snooped update data |
| snpShared | output | 1 | This cache holds the snooped block |
| snpFlush | output | 1 | This cache supplies the snooped block |
| snpFlushData | output | WORDS*WORD_W | Flushed block |

## Verification
The hardest states to reach from the ports are the owner states. Telling shared-modified apart from modified, and both apart from shared-clean, needs a chain of transactions: a fill with a chosen shared response, a local write, and then snooped reads or updates that show the state through the flush and shared outputs. Each scenario drives exactly such a chain. The bench plays the other caches and the arbiter, and picks the shared response for each grant. The replacement cases first make an index dirty through a specific sequence, then force a conflict miss to it. The bench checks the writeback's order, address and payload against its own memory model.

// File: rtl/wbu_coh_pkg.sv
`timescale 1ns/1ps
package wbu_coh_pkg;
  typedef enum logic [1:0] {
    LS_EXCL    = 2'd0,
    LS_SHCLEAN = 2'd1,
    LS_SHMOD   = 2'd2,
    LS_MOD     = 2'd3
  } lineState_e;

  typedef enum logic [1:0] {
    BC_IDLE   = 2'd0,
    BC_READ   = 2'd1,
    BC_UPDATE = 2'd2,
    BC_WRBACK = 2'd3
  } busCmd_e;

  typedef struct packed {
    logic       fill;
    logic       fillShared;
    logic       wrWord;
    logic       setState;
    lineState_e newState;
    logic       evict;
  } dpStrobe_t;
endpackage

// File: rtl/wbu_datapath.sv
`timescale 1ns/1ps
module wbu_datapath
  import wbu_coh_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int WORDS     = 4,
  parameter int WORD_W    = 32,
  parameter int ADDR_W    = 12,
  localparam int OFF_W    = $clog2(WORDS),
  localparam int IDX_W    = $clog2(NUM_LINES),
  localparam int BLK_AW   = ADDR_W - OFF_W,
  localparam int TAG_W    = BLK_AW - IDX_W,
  localparam int BLK_W    = WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [WORD_W-1:0] cpuWdata,
  input  busCmd_e           busCmd,
  input  logic              busGnt,
  input  logic [BLK_W-1:0]  busFillData,
  input  logic              snpValid,
  input  logic [1:0]        snpCmd,
  input  logic [BLK_AW-1:0] snpAddr,
  input  logic [OFF_W-1:0]  snpWord,
  input  logic [WORD_W-1:0] snpWordData,
  output logic              cpuHit,
  output lineState_e        cpuState,
  output logic              victimDirty,
  output logic [WORD_W-1:0] cpuRdata,
  output logic [BLK_AW-1:0] busAddr,
  output logic [OFF_W-1:0]  busWord,
  output logic [WORD_W-1:0] busWordData,
  output logic [BLK_W-1:0]  busBlockOut,
  output logic              snpShared,
  output logic              snpFlush,
  output logic [BLK_W-1:0]  snpFlushData
);
  logic             presentQ [NUM_LINES];
  logic [TAG_W-1:0] tagQ     [NUM_LINES];
  lineState_e       stateQ   [NUM_LINES];
  logic [BLK_W-1:0] dataQ    [NUM_LINES];

  logic [BLK_AW-1:0] reqBlk;
  logic [OFF_W-1:0]  reqOff;
  logic [IDX_W-1:0]  reqIdx;
  logic [TAG_W-1:0]  reqTag;
  logic [IDX_W-1:0]  snpIdx;
  logic [TAG_W-1:0]  snpTag;
  logic              snpHit;
  logic              snpIsUpd;

  assign reqBlk = cpuAddr[ADDR_W-1:OFF_W];
  assign reqOff = cpuAddr[OFF_W-1:0];
  assign reqIdx = reqBlk[IDX_W-1:0];
  assign reqTag = reqBlk[BLK_AW-1:IDX_W];
  assign snpIdx = snpAddr[IDX_W-1:0];
  assign snpTag = snpAddr[BLK_AW-1:IDX_W];

  // processor-side lookup
  assign cpuHit      = presentQ[reqIdx] && (tagQ[reqIdx] == reqTag);
  assign cpuState    = stateQ[reqIdx];
  assign victimDirty = presentQ[reqIdx] &&
                       (stateQ[reqIdx] == LS_MOD || stateQ[reqIdx] == LS_SHMOD);
  assign cpuRdata    = dataQ[reqIdx][reqOff*WORD_W +: WORD_W];

  // bus master fields; a writeback names the victim block
  assign busAddr     = (busCmd == BC_WRBACK) ? {tagQ[reqIdx], reqIdx} : reqBlk;
  assign busWord     = reqOff;
  assign busWordData = cpuWdata;
  assign busBlockOut = dataQ[reqIdx];

  // snoop side
  assign snpIsUpd     = (snpCmd == BC_UPDATE);
  assign snpHit       = snpValid && presentQ[snpIdx] && (tagQ[snpIdx] == snpTag) &&
                        (snpCmd == BC_READ || snpIsUpd);
  assign snpShared    = snpHit;
  assign snpFlush     = snpHit && !snpIsUpd &&
                        (stateQ[snpIdx] == LS_MOD || stateQ[snpIdx] == LS_SHMOD);
  assign snpFlushData = dataQ[snpIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_LINES; i++) begin
        presentQ[i] <= 1'b0;
        tagQ[i]     <= '0;
        stateQ[i]   <= LS_EXCL;
      end
    end else begin
      if (strb.evict) presentQ[reqIdx] <= 1'b0;
      if (strb.fill) begin
        presentQ[reqIdx] <= 1'b1;
        tagQ[reqIdx]     <= reqTag;
        stateQ[reqIdx]   <= strb.fillShared ? LS_SHCLEAN : LS_EXCL;
      end
      if (strb.setState) stateQ[reqIdx] <= strb.newState;
      if (snpHit) begin
        if (snpIsUpd)                        stateQ[snpIdx] <= LS_SHCLEAN;
        else if (stateQ[snpIdx] == LS_MOD)   stateQ[snpIdx] <= LS_SHMOD;
        else if (stateQ[snpIdx] == LS_EXCL)  stateQ[snpIdx] <= LS_SHCLEAN;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.fill)   dataQ[reqIdx] <= busFillData;
    if (strb.wrWord) dataQ[reqIdx][reqOff*WORD_W +: WORD_W] <= cpuWdata;
    if (snpHit && snpIsUpd) dataQ[snpIdx][snpWord*WORD_W +: WORD_W] <= snpWordData;
  end

  // R8
  flush_has_shared_chk: assert property (@(posedge clk) disable iff (!rstN)
    snpFlush |-> snpShared);

  // R3
  update_from_shared_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busGnt && busCmd == BC_UPDATE) |->
      (cpuHit && (cpuState == LS_SHCLEAN || cpuState == LS_SHMOD)));
endmodule

// File: rtl/wbu_ctrl.sv
`timescale 1ns/1ps
module wbu_ctrl
  import wbu_coh_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuReq,
  input  logic       cpuWr,
  input  logic       cpuHit,
  input  lineState_e cpuState,
  input  logic       victimDirty,
  input  logic       busGnt,
  input  logic       busShared,
  input  logic       snpValid,
  output logic       cpuDone,
  output logic       busReq,
  output busCmd_e    busCmd,
  output dpStrobe_t  strb
);
  typedef enum logic [1:0] {CS_IDLE, CS_WRBACK, CS_READ, CS_UPDATE} ctlState_e;
  ctlState_e stQ, stD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stQ <= CS_IDLE;
    else       stQ <= stD;
  end

  always_comb begin
    stD     = stQ;
    strb    = '0;
    cpuDone = 1'b0;
    busReq  = 1'b0;
    busCmd  = BC_IDLE;
    unique case (stQ)
      CS_IDLE: begin
        if (cpuReq && !snpValid) begin
          if (cpuHit) begin
            if (!cpuWr) begin
              cpuDone = 1'b1;
            end else if (cpuState == LS_EXCL || cpuState == LS_MOD) begin
              strb.wrWord   = 1'b1;
              strb.setState = 1'b1;
              strb.newState = LS_MOD;
              cpuDone       = 1'b1;
            end else begin
              stD = CS_UPDATE;
            end
          end else begin
            stD = victimDirty ? CS_WRBACK : CS_READ;
          end
        end
      end
      CS_WRBACK: begin
        busReq = 1'b1;
        busCmd = BC_WRBACK;
        if (busGnt) begin
          strb.evict = 1'b1;
          stD        = CS_READ;
        end
      end
      CS_READ: begin
        busReq = 1'b1;
        busCmd = BC_READ;
        if (busGnt) begin
          strb.fill       = 1'b1;
          strb.fillShared = busShared;
          stD             = CS_IDLE;
        end
      end
      CS_UPDATE: begin
        busReq = 1'b1;
        busCmd = BC_UPDATE;
        if (busGnt) begin
          strb.wrWord   = 1'b1;
          strb.setState = 1'b1;
          strb.newState = busShared ? LS_SHMOD : LS_MOD;
          cpuDone       = 1'b1;
          stD           = CS_IDLE;
        end
      end
      default: stD = CS_IDLE;
    endcase
  end

  // R10
  wb_then_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busGnt && busCmd == BC_WRBACK) |=> (busReq && busCmd == BC_READ));

  // R2
  req_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busGnt && cpuReq) |=> (busReq && $stable(busCmd)));

  // R1
  done_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuDone |-> cpuReq);

  // R7
  grant_snoop_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    busGnt |-> !snpValid);
endmodule

// File: rtl/wbu_coherence_ctrl.sv
`timescale 1ns/1ps
module wbu_coherence_ctrl
  import wbu_coh_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int WORDS     = 4,
  parameter int WORD_W    = 32,
  parameter int ADDR_W    = 12,
  localparam int OFF_W    = $clog2(WORDS),
  localparam int BLK_AW   = ADDR_W - OFF_W,
  localparam int BLK_W    = WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuReq,
  input  logic              cpuWr,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [WORD_W-1:0] cpuWdata,
  output logic [WORD_W-1:0] cpuRdata,
  output logic              cpuDone,
  output logic              busReq,
  input  logic              busGnt,
  output logic [1:0]        busCmd,
  output logic [BLK_AW-1:0] busAddr,
  output logic [OFF_W-1:0]  busWord,
  output logic [WORD_W-1:0] busWordData,
  output logic [BLK_W-1:0]  busBlockOut,
  input  logic [BLK_W-1:0]  busFillData,
  input  logic              busShared,
  input  logic              snpValid,
  input  logic [1:0]        snpCmd,
  input  logic [BLK_AW-1:0] snpAddr,
  input  logic [OFF_W-1:0]  snpWord,
  input  logic [WORD_W-1:0] snpWordData,
  output logic              snpShared,
  output logic              snpFlush,
  output logic [BLK_W-1:0]  snpFlushData
);
  dpStrobe_t  strb;
  busCmd_e    cmdInt;
  logic       cpuHit;
  lineState_e cpuState;
  logic       victimDirty;

  assign busCmd = cmdInt;

  wbu_ctrl ctrl_i (
    .clk, .rstN, .cpuReq, .cpuWr, .cpuHit, .cpuState, .victimDirty,
    .busGnt, .busShared, .snpValid, .cpuDone, .busReq,
    .busCmd(cmdInt), .strb
  );

  wbu_datapath #(
    .NUM_LINES(NUM_LINES), .WORDS(WORDS), .WORD_W(WORD_W), .ADDR_W(ADDR_W)
  ) dp_i (
    .clk, .rstN, .strb, .cpuAddr, .cpuWdata, .busCmd(cmdInt), .busGnt,
    .busFillData, .snpValid, .snpCmd, .snpAddr, .snpWord, .snpWordData,
    .cpuHit, .cpuState, .victimDirty, .cpuRdata, .busAddr, .busWord,
    .busWordData, .busBlockOut, .snpShared, .snpFlush, .snpFlushData
  );
endmodule

// File: tb/wbu_coherence_ctrl_tb.sv
`timescale 1ns/1ps
module wbu_coherence_ctrl_tb_top;
  localparam int AW = 12, WW = 32, BAW = 10, BW = 128;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN;
  logic cpuReq, cpuWr, cpuDone, busReq, busGnt, busShared;
  logic [AW-1:0] cpuAddr;
  logic [WW-1:0] cpuWdata, cpuRdata, busWordData, snpWordData;
  logic [1:0] busCmd, snpCmd, busWord, snpWord;
  logic [BAW-1:0] busAddr, snpAddr;
  logic [BW-1:0] busBlockOut, busFillData, snpFlushData;
  logic snpValid, snpShared, snpFlush;

  wbu_coherence_ctrl dut_i (.*);

  int nChecks = 0, nFails = 0;
  logic [BW-1:0] mem [64];

  logic [1:0]     txCmd  [8];
  logic [BAW-1:0] txAddr [8];
  logic [1:0]     txWord [8];
  logic [WW-1:0]  txData [8];
  logic [BW-1:0]  txBlk  [8];
  int txCount;

  localparam logic [31:0] D_A = 32'h1111_2222, D_B = 32'h3333_4444,
    D_C = 32'h5555_6666, D_D = 32'h7777_8888, D_E = 32'h9999_AAAA,
    D_F = 32'hBBBB_CCCC, D_G = 32'hDDDD_EEEE, D_H = 32'h0F0F_F0F0;

  function automatic logic [31:0] memWord(int blk, int w);
    return 32'hC000_0000 | (blk << 8) | w;
  endfunction

  function automatic logic [AW-1:0] wa(int blk, int w);
    return AW'((blk << 2) | w);
  endfunction

  function automatic logic [31:0] wordOf(logic [BW-1:0] b, int w);
    return b[w*32 +: 32];
  endfunction

  task automatic chk(string req, string what, logic [127:0] act, logic [127:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cpuOp(bit wr, logic [AW-1:0] addr, logic [31:0] wdata, bit shr,
                       output logic [31:0] rdata);
    bit done = 0;
    int cyc = 0;
    txCount = 0;
    rdata = '0;
    @(negedge clk);
    cpuReq = 1; cpuWr = wr; cpuAddr = addr; cpuWdata = wdata;
    while (!done && cyc < 40) begin
      #0.5;
      if (busReq) begin
        if (txCount < 8) begin
          txCmd[txCount] = busCmd; txAddr[txCount] = busAddr;
          txWord[txCount] = busWord; txData[txCount] = busWordData;
          txBlk[txCount] = busBlockOut;
        end
        txCount++;
        busGnt = 1; busShared = shr;
        busFillData = mem[busAddr[5:0]];
        if (busCmd == 2'd3) mem[busAddr[5:0]] = busBlockOut;
      end
      #0.5;
      if (cpuDone) begin done = 1; rdata = cpuRdata; end
      @(negedge clk);
      busGnt = 0; busShared = 0;
      cyc++;
    end
    cpuReq = 0; cpuWr = 0;
    if (!done) chk("R2", "request completion", 0, 1);
  endtask

  task automatic snoopOp(logic [1:0] cmd, int blk, int w, logic [31:0] d,
                         output logic sh, output logic fl, output logic [BW-1:0] fd);
    @(negedge clk);
    snpValid = 1; snpCmd = cmd; snpAddr = BAW'(blk); snpWord = 2'(w); snpWordData = d;
    #0.5;
    sh = snpShared; fl = snpFlush; fd = snpFlushData;
    @(negedge clk);
    snpValid = 0; snpCmd = 0;
  endtask

  logic [31:0] rd;
  logic sh, fl;
  logic [BW-1:0] fd;

  task automatic testReset();
    chk("R1", "busReq after reset", busReq, 0);
    chk("R1", "cpuDone after reset", cpuDone, 0);
    snoopOp(2'd1, 4, 0, 0, sh, fl, fd);
    chk("R1", "shared on empty cache", sh, 0);
    chk("R1", "flush on empty cache", fl, 0);
  endtask

  task automatic testExclusive();
    cpuOp(0, wa(4, 1), 0, 0, rd);
    chk("R2", "read miss txn count", txCount, 1);
    chk("R2", "read miss cmd", txCmd[0], 1);
    chk("R2", "read miss addr", txAddr[0], 4);
    chk("R2", "read miss data", rd, memWord(4, 1));
    cpuOp(1, wa(4, 2), D_A, 0, rd);
    chk("R9", "write to exclusive txns", txCount, 0);
  endtask

  task automatic testSnoopDirty();
    snoopOp(2'd1, 4, 0, 0, sh, fl, fd);
    chk("R8", "shared on modified", sh, 1);
    chk("R8", "flush on modified", fl, 1);
    chk("R8", "flushed written word", wordOf(fd, 2), D_A);
    chk("R8", "flushed fill word", wordOf(fd, 1), memWord(4, 1));
    snoopOp(2'd1, 4, 0, 0, sh, fl, fd);
    chk("R8", "shared-modified still flushes", fl, 1);
    cpuOp(1, wa(4, 0), D_B, 0, rd);
    chk("R4", "owner write txns", txCount, 1);
    chk("R4", "owner write cmd", txCmd[0], 2);
    chk("R4", "owner write word", txWord[0], 0);
    chk("R4", "owner write data", txData[0], D_B);
    snoopOp(2'd1, 4, 0, 0, sh, fl, fd);
    chk("R4", "flush after lone update", fl, 1);
    chk("R4", "flushed update word", wordOf(fd, 0), D_B);
  endtask

  task automatic testExclShare();
    cpuOp(0, wa(5, 0), 0, 0, rd);
    snoopOp(2'd1, 5, 0, 0, sh, fl, fd);
    chk("R9", "shared on exclusive", sh, 1);
    chk("R9", "no flush on exclusive", fl, 0);
    cpuOp(1, wa(5, 1), D_C, 1, rd);
    chk("R9", "write after share txns", txCount, 1);
    chk("R3", "update cmd", txCmd[0], 2);
    snoopOp(2'd1, 5, 0, 0, sh, fl, fd);
    chk("R3", "shared-modified flushes", fl, 1);
    chk("R3", "flushed word", wordOf(fd, 1), D_C);
  endtask

  task automatic testSnoopUpdate();
    snoopOp(2'd2, 5, 3, D_D, sh, fl, fd);
    chk("R7", "shared on update", sh, 1);
    chk("R7", "no flush on update", fl, 0);
    cpuOp(0, wa(5, 3), 0, 0, rd);
    chk("R7", "hit after update txns", txCount, 0);
    chk("R7", "updated word", rd, D_D);
    snoopOp(2'd1, 5, 0, 0, sh, fl, fd);
    chk("R7", "former owner shared", sh, 1);
    chk("R7", "former owner no flush", fl, 0);
  endtask

  task automatic testWriteMissShared();
    cpuOp(1, wa(6, 2), D_E, 1, rd);
    chk("R6", "txn count", txCount, 2);
    chk("R6", "first cmd read", txCmd[0], 1);
    chk("R6", "second cmd update", txCmd[1], 2);
    chk("R6", "update word", txWord[1], 2);
    chk("R6", "update data", txData[1], D_E);
    snoopOp(2'd1, 6, 0, 0, sh, fl, fd);
    chk("R6", "owner flush", fl, 1);
    chk("R6", "flushed word", wordOf(fd, 2), D_E);
  endtask

  task automatic testWriteMissExcl();
    cpuOp(1, wa(11, 1), D_F, 0, rd);
    chk("R5", "txn count", txCount, 1);
    chk("R5", "cmd read", txCmd[0], 1);
    snoopOp(2'd1, 11, 0, 0, sh, fl, fd);
    chk("R5", "modified flush", fl, 1);
    chk("R5", "flushed word", wordOf(fd, 1), D_F);
  endtask

  task automatic testReplace();
    cpuOp(0, wa(15, 0), 0, 0, rd);
    chk("R10", "dirty victim txns", txCount, 2);
    chk("R10", "writeback first", txCmd[0], 3);
    chk("R10", "writeback addr", txAddr[0], 11);
    chk("R10", "writeback data", wordOf(txBlk[0], 1), D_F);
    chk("R10", "then read", txCmd[1], 1);
    chk("R10", "read addr", txAddr[1], 15);
    chk("R10", "read data", rd, memWord(15, 0));
    cpuOp(0, wa(19, 2), 0, 0, rd);
    chk("R10", "clean victim txns", txCount, 1);
    chk("R10", "clean victim cmd", txCmd[0], 1);
    chk("R10", "clean victim read data", rd, memWord(19, 2));
  endtask

  task automatic testIgnore();
    snoopOp(2'd2, 23, 1, D_G, sh, fl, fd);
    chk("R11", "absent update shared", sh, 0);
    chk("R11", "absent update flush", fl, 0);
    cpuOp(0, wa(19, 1), 0, 0, rd);
    chk("R11", "resident line txns", txCount, 0);
    chk("R11", "resident word untouched", rd, memWord(19, 1));
    snoopOp(2'd1, 23, 0, 0, sh, fl, fd);
    chk("R11", "absent read shared", sh, 0);
  endtask

  task automatic testSharedAlone();
    cpuOp(0, wa(8, 0), 0, 1, rd);
    chk("R10", "owner victim txns", txCount, 2);
    chk("R10", "owner victim writeback", txCmd[0], 3);
    chk("R10", "writeback carries update", wordOf(txBlk[0], 0), D_B);
    snoopOp(2'd1, 8, 0, 0, sh, fl, fd);
    chk("R3", "shared-clean no flush", fl, 0);
    cpuOp(1, wa(8, 3), D_H, 0, rd);
    chk("R4", "shared write txns", txCount, 1);
    chk("R4", "shared write cmd", txCmd[0], 2);
    snoopOp(2'd1, 8, 0, 0, sh, fl, fd);
    chk("R4", "now modified flushes", fl, 1);
    chk("R4", "flushed word", wordOf(fd, 3), D_H);
  endtask

  bit finished = 0;

  initial begin
    for (int b = 0; b < 64; b++)
      for (int w = 0; w < 4; w++) mem[b][w*32 +: 32] = memWord(b, w);
    rstN = 0; cpuReq = 0; cpuWr = 0; cpuAddr = 0; cpuWdata = 0;
    busGnt = 0; busShared = 0; busFillData = 0;
    snpValid = 0; snpCmd = 0; snpAddr = 0; snpWord = 0; snpWordData = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testExclusive();
    testSnoopDirty();
    testExclShare();
    testSnoopUpdate();
    testWriteMissShared();
    testWriteMissExcl();
    testReplace();
    testIgnore();
    testSharedAlone();
    finished = 1;
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule